// File: doc/BRIEF.md
# Round-Robin Monitor Sequencer with Limit Interrupts

This block is the sequencing core of a hardware monitor. It steps through a fixed list of nine measurement channels: temperature, the 2.5 V sense or second processor supply, +12 V, +5 V, +3.3 V, +2.5 V, the first processor supply, fan 1 and fan 2. It issues one conversion request per time slot. Each returned reading is written into a reading register and compared against limits that the host programs. A violation sets a sticky status bit, and reading the status register clears it.

An active-low interrupt output is driven when any unmasked status bit is set. The global enable bit in the configuration register must also be on, and the interrupt-clear bit must be off. The converter and fan counters sit outside the block and are reached through a request/ready/data handshake. When the host stops the sequencer, the current pass finishes before the block halts. Every restart begins at the temperature channel.

Top module: `rr_monitor`

## Requirements
- R1: After reset, `int_n` is 1 and `conv_req` is 0. The configuration register (address 0x00) reads 0x08, which means the interrupt-clear bit is set, so no request is issued until the host writes the configuration. Both status registers (0x01, 0x02) read 0.
- R2: Requests follow the channel codes 0 to 8 in this order: 0 temperature, 1 sense/second processor supply, 2 +12 V, 3 +5 V, 4 +3.3 V, 5 +2.5 V, 6 first processor supply, 7 fan 1, 8 fan 2. `conv_req` holds with a stable `conv_ch` until `conv_rdy` is seen.
- R3: When the converter answers within a slot, consecutive requests start exactly LOOP_CYCLES/9 clock cycles apart.
- R4: A reading accepted on channel c can be read back at address 0x10+c.
- R5: For channels 1 to 6, a reading above the high limit (0x20+c) or below the low limit (0x30+c) sets status bit c. A reading equal to either limit sets nothing. Status register 1 (0x01) holds channels 0 to 7 in bits 0 to 7. Status register 2 (0x02) holds channel 8 in bit 0.
- R6: Channel 0 compares the reading and its limits as two's-complement values.
- R7: For the fan channels 7 and 8, the only fault is a count strictly above the limit at 0x27 or 0x28. A count of 255 is a fault whenever the limit is below 255.
- R8: Status bits stay set across later in-range passes until their register is read. The read returns them and clears them.
- R9: Mask bits (0x03 bits 0 to 7 for channels 0 to 7, 0x04 bit 0 for channel 8; 1 means suppress) keep a source off `int_n`. The status bit is still set.
- R10: Configuration bit 1 enables `int_n`. With it at 0, `int_n` stays 1 even when unmasked faults are pending. Setting it drives `int_n` to 0 within two cycles while such a fault is pending.
- R11: Setting configuration bit 3 returns `int_n` to 1 within two cycles and leaves the status contents unchanged. It also halts monitoring at the end of the current pass.
- R12: Clearing configuration bit 0 in the middle of a pass lets the remaining channels of that pass through channel 8 be requested. No request follows them.
- R13: After a halt, writing bit 0 = 1 with bit 3 = 0 makes the first new request use channel 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host register write strobe |
| host_rd | input | 1 | Host register read strobe; data appears on host_rdata after the next edge |
| host_addr | input | 6 | Host register address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Registered host read data |
| conv_req | output | 1 | Conversion request, held until conv_rdy |
| conv_ch | output | 4 | Channel code of the current request |
| conv_rdy | input | 1 | Converter result valid; accepted while conv_req is high |
| conv_data | input | 8 | Converter result |
| int_n | output | 1 | Active-low interrupt |

## Verification
The assertions assume that the converter raises `conv_rdy` only while `conv_req` is high and holds it for at most one cycle per request. They also assume that the host never reads and writes in the same cycle. The bench's converter model answers each request once, after a random latency of zero to three cycles, and drops ready at the next falling edge. That latency always fits inside a slot, which is what lets the exact spacing of R3 hold. Host accesses come from one task at a time. Readings are drawn from a fixed-seed generator and mixed with directed values at, just above and just below each limit.

// File: rtl/rr_mon_pkg.sv
// Package: shared constants and types for the round-robin monitor.
// Assumes the channel list is fixed at nine, so the status split across two
// byte-wide registers is fixed as well (eight plus one).
package rr_mon_pkg;
    localparam int DATA_W  = 8;
    localparam int NUM_CH  = 9;
    localparam int NUM_FAN = 2;
    localparam int NUM_VCH = NUM_CH - NUM_FAN;
    localparam int CH_W    = $clog2(NUM_CH);
    localparam int ADDR_W  = 6;

    typedef enum logic [CH_W-1:0] {
        CH_TEMP  = 4'd0,
        CH_VSNS  = 4'd1,
        CH_P12   = 4'd2,
        CH_P5    = 4'd3,
        CH_P33   = 4'd4,
        CH_P25   = 4'd5,
        CH_VCPU  = 4'd6,
        CH_FAN1  = 4'd7,
        CH_FAN2  = 4'd8
    } chan_e;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_REQ  = 2'd1,
        SQ_HOLD = 2'd2
    } seq_state_e;

    localparam logic [ADDR_W-1:0] ADDR_CFG  = 6'h00;
    localparam logic [ADDR_W-1:0] ADDR_ST1  = 6'h01;
    localparam logic [ADDR_W-1:0] ADDR_ST2  = 6'h02;
    localparam logic [ADDR_W-1:0] ADDR_MK1  = 6'h03;
    localparam logic [ADDR_W-1:0] ADDR_MK2  = 6'h04;
    localparam logic [ADDR_W-1:0] BASE_VAL  = 6'h10;
    localparam logic [ADDR_W-1:0] BASE_HI   = 6'h20;
    localparam logic [ADDR_W-1:0] BASE_LO   = 6'h30;

    localparam int CFG_RUN = 0;
    localparam int CFG_IE  = 1;
    localparam int CFG_CLR = 3;
    localparam logic [DATA_W-1:0] CFG_RESET = 8'h08;
    localparam logic [DATA_W-1:0] CFG_WMASK = 8'h0B;
endpackage

// File: rtl/rr_mon_seq.sv
// Module: slot sequencer. Walks the channel list one slot per channel, holds a
// request until the converter answers, and re-checks the run condition only
// at the end of the last slot, so a stop always completes the pass.
// Assumes SLOT_CYCLES >= 2 and conv_rdy is only meaningful while conv_req is high.
module rr_mon_seq
    import rr_mon_pkg::*;
#(
    parameter int SLOT_CYCLES = 100
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            conv_rdy,
    output logic            conv_req,
    output logic [CH_W-1:0] conv_ch,
    output logic            cap_valid
);
    localparam int CNT_W = $clog2(SLOT_CYCLES) + 1;
    localparam logic [CNT_W-1:0] SLOT_LAST = CNT_W'(SLOT_CYCLES - 1);
    localparam logic [CH_W-1:0]  CH_LAST   = CH_W'(NUM_CH - 1);

    seq_state_e       state;
    logic [CH_W-1:0]  ch;
    logic [CNT_W-1:0] cnt;

    // Purpose: state, channel pointer and slot timer of the round robin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SQ_IDLE;
            ch    <= '0;
            cnt   <= '0;
        end else begin
            case (state)
                SQ_IDLE: begin
                    if (run) begin
                        state <= SQ_REQ;
                        ch    <= CH_TEMP;
                        cnt   <= '0;
                    end
                end
                SQ_REQ: begin
                    if (cnt != SLOT_LAST) begin
                        cnt <= cnt + 1'b1;
                    end
                    if (conv_rdy) begin
                        state <= SQ_HOLD;
                    end
                end
                SQ_HOLD: begin
                    if (cnt == SLOT_LAST) begin
                        cnt <= '0;
                        if (ch == CH_LAST) begin
                            ch    <= CH_TEMP;
                            state <= run ? SQ_REQ : SQ_IDLE;
                        end else begin
                            ch    <= ch + 1'b1;
                            state <= SQ_REQ;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    assign conv_req  = (state == SQ_REQ);
    assign conv_ch   = ch;
    assign cap_valid = conv_req && conv_rdy;
endmodule

// File: rtl/rr_mon_cmp.sv
// Module: limit comparator. Decides whether one reading violates its limits:
// a signed window for temperature, an unsigned window for supplies and a
// single upper bound for fan period counts.
// Assumes lo is ignored for fan channels.
module rr_mon_cmp
    import rr_mon_pkg::*;
(
    input  logic [CH_W-1:0]   ch,
    input  logic [DATA_W-1:0] data,
    input  logic [DATA_W-1:0] hi,
    input  logic [DATA_W-1:0] lo,
    output logic              fault
);
    // Purpose: select the comparison rule by channel class.
    always_comb begin
        if (ch >= CH_FAN1) begin
            fault = (data > hi);
        end else if (ch == CH_TEMP) begin
            fault = ($signed(data) > $signed(hi)) || ($signed(data) < $signed(lo));
        end else begin
            fault = (data > hi) || (data < lo);
        end
    end
endmodule

// File: rtl/rr_mon_regs.sv
// Module: register file. Holds configuration, masks, limits, readings and
// sticky status; serves host reads through a registered data port.
// Assumes a host read and a fault set in the same cycle: the set wins.
module rr_mon_regs
    import rr_mon_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              cap_valid,
    input  logic [CH_W-1:0]   cap_ch,
    input  logic [DATA_W-1:0] cap_data,
    input  logic              cap_fault,
    output logic [DATA_W-1:0] hi_sel,
    output logic [DATA_W-1:0] lo_sel,
    output logic [NUM_CH-1:0] stat,
    output logic [NUM_CH-1:0] mask,
    output logic              cfg_run,
    output logic              cfg_ie,
    output logic              cfg_clr
);
    logic [DATA_W-1:0] cfg;
    logic [DATA_W-1:0] val_q [NUM_CH];
    logic [DATA_W-1:0] hi_q  [NUM_CH];
    logic [DATA_W-1:0] lo_q  [NUM_VCH];
    logic [DATA_W-1:0] rd_mux;
    logic [NUM_CH-1:0] stat_nxt;

    // Purpose: configuration register, only the defined bits are writable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= CFG_RESET;
        end else if (host_wr && host_addr == ADDR_CFG) begin
            cfg <= host_wdata & CFG_WMASK;
        end
    end

    assign cfg_run = cfg[CFG_RUN];
    assign cfg_ie  = cfg[CFG_IE];
    assign cfg_clr = cfg[CFG_CLR];

    // Purpose: per-source interrupt masks split across two registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask <= '0;
        end else if (host_wr) begin
            if (host_addr == ADDR_MK1) begin
                mask[DATA_W-1:0] <= host_wdata;
            end
            if (host_addr == ADDR_MK2) begin
                mask[NUM_CH-1] <= host_wdata[0];
            end
        end
    end

    genvar gi;
    generate
        for (gi = 0; gi < NUM_CH; gi++) begin : g_chan
            // Purpose: reading of one channel, written by the sequencer.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    val_q[gi] <= '0;
                end else if (cap_valid && cap_ch == CH_W'(gi)) begin
                    val_q[gi] <= cap_data;
                end
            end
            // Purpose: high (or fan) limit of one channel, written by the host.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    hi_q[gi] <= '0;
                end else if (host_wr && host_addr == (BASE_HI + ADDR_W'(gi))) begin
                    hi_q[gi] <= host_wdata;
                end
            end
        end
        for (gi = 0; gi < NUM_VCH; gi++) begin : g_low
            // Purpose: low limit of one windowed channel, written by the host.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    lo_q[gi] <= '0;
                end else if (host_wr && host_addr == (BASE_LO + ADDR_W'(gi))) begin
                    lo_q[gi] <= host_wdata;
                end
            end
        end
    endgenerate

    // Purpose: pick the limits of the channel being captured.
    always_comb begin
        hi_sel = '0;
        lo_sel = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (cap_ch == CH_W'(i)) hi_sel = hi_q[i];
        end
        for (int i = 0; i < NUM_VCH; i++) begin
            if (cap_ch == CH_W'(i)) lo_sel = lo_q[i];
        end
    end

    // Purpose: sticky status next state, read clears first, then faults set.
    always_comb begin
        stat_nxt = stat;
        if (host_rd && host_addr == ADDR_ST1) stat_nxt[DATA_W-1:0] = '0;
        if (host_rd && host_addr == ADDR_ST2) stat_nxt[NUM_CH-1]   = 1'b0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (cap_valid && cap_fault && cap_ch == CH_W'(i)) stat_nxt[i] = 1'b1;
        end
    end

    // Purpose: sticky status register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat <= '0;
        end else begin
            stat <= stat_nxt;
        end
    end

    // Purpose: host read multiplexer over all address windows.
    always_comb begin
        rd_mux = '0;
        if (host_addr == ADDR_CFG) rd_mux = cfg;
        if (host_addr == ADDR_ST1) rd_mux = stat[DATA_W-1:0];
        if (host_addr == ADDR_ST2) rd_mux = {{(DATA_W-1){1'b0}}, stat[NUM_CH-1]};
        if (host_addr == ADDR_MK1) rd_mux = mask[DATA_W-1:0];
        if (host_addr == ADDR_MK2) rd_mux = {{(DATA_W-1){1'b0}}, mask[NUM_CH-1]};
        for (int i = 0; i < NUM_CH; i++) begin
            if (host_addr == (BASE_VAL + ADDR_W'(i))) rd_mux = val_q[i];
            if (host_addr == (BASE_HI + ADDR_W'(i)))  rd_mux = hi_q[i];
        end
        for (int i = 0; i < NUM_VCH; i++) begin
            if (host_addr == (BASE_LO + ADDR_W'(i))) rd_mux = lo_q[i];
        end
    end

    // Purpose: registered host read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_rdata <= '0;
        end else if (host_rd) begin
            host_rdata <= rd_mux;
        end
    end
endmodule

// File: rtl/rr_mon_irq.sv
// Module: interrupt output stage. Drives the registered active-low line from
// unmasked pending status, the global enable and the clear control.
// Assumes status and mask are bit-aligned per channel.
module rr_mon_irq
    import rr_mon_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] stat,
    input  logic [NUM_CH-1:0] mask,
    input  logic              cfg_ie,
    input  logic              cfg_clr,
    output logic              int_n
);
    logic pend;

    assign pend = |(stat & ~mask);

    // Purpose: register the interrupt line, idle high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            int_n <= 1'b1;
        end else begin
            int_n <= !(cfg_ie && !cfg_clr && pend);
        end
    end
endmodule

// File: rtl/rr_monitor.sv
// Module: top of the round-robin monitor. Ties the sequencer, comparator,
// register file and interrupt stage together.
// Assumes LOOP_CYCLES is at least twice the channel count.
module rr_monitor
    import rr_mon_pkg::*;
#(
    parameter int LOOP_CYCLES = 900
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              conv_req,
    output logic [CH_W-1:0]   conv_ch,
    input  logic              conv_rdy,
    input  logic [DATA_W-1:0] conv_data,
    output logic              int_n
);
    localparam int SLOT_CYCLES = LOOP_CYCLES / NUM_CH;

    logic              cap_valid;
    logic              cap_fault;
    logic [DATA_W-1:0] hi_sel;
    logic [DATA_W-1:0] lo_sel;
    logic [NUM_CH-1:0] stat;
    logic [NUM_CH-1:0] mask;
    logic              cfg_run;
    logic              cfg_ie;
    logic              cfg_clr;
    logic              run;

    assign run = cfg_run && !cfg_clr;

    rr_mon_seq #(.SLOT_CYCLES(SLOT_CYCLES)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .conv_rdy  (conv_rdy),
        .conv_req  (conv_req),
        .conv_ch   (conv_ch),
        .cap_valid (cap_valid)
    );

    rr_mon_cmp u_cmp (
        .ch    (conv_ch),
        .data  (conv_data),
        .hi    (hi_sel),
        .lo    (lo_sel),
        .fault (cap_fault)
    );

    rr_mon_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .cap_valid  (cap_valid),
        .cap_ch     (conv_ch),
        .cap_data   (conv_data),
        .cap_fault  (cap_fault),
        .hi_sel     (hi_sel),
        .lo_sel     (lo_sel),
        .stat       (stat),
        .mask       (mask),
        .cfg_run    (cfg_run),
        .cfg_ie     (cfg_ie),
        .cfg_clr    (cfg_clr)
    );

    rr_mon_irq u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .stat    (stat),
        .mask    (mask),
        .cfg_ie  (cfg_ie),
        .cfg_clr (cfg_clr),
        .int_n   (int_n)
    );
endmodule

// File: rtl/rr_monitor_chk.sv
// Module: assertion checker bound to the monitor top.
// Assumes conv_rdy only rises while conv_req is high.
module rr_monitor_chk
    import rr_mon_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              conv_req,
    input logic [CH_W-1:0]   conv_ch,
    input logic              conv_rdy,
    input logic              int_n,
    input logic              cfg_ie,
    input logic              cfg_clr,
    input logic [NUM_CH-1:0] stat,
    input logic [NUM_CH-1:0] mask,
    input logic              host_rd,
    input logic [ADDR_W-1:0] host_addr
);
    logic [CH_W-1:0] last_ch;

    // Purpose: remember the channel of the last accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_ch <= '0;
        end else if (conv_req && conv_rdy) begin
            last_ch <= conv_ch;
        end
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_req && !conv_rdy) |=> (conv_req && $stable(conv_ch))); // R2

    AST_CH_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req |-> (conv_ch < CH_W'(NUM_CH))); // R2

    AST_CH_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(conv_req) |-> ((conv_ch == CH_TEMP) || (32'(conv_ch) == 32'(last_ch) + 1))); // R13

    AST_INT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_ie || cfg_clr) |=> int_n); // R11

    AST_INT_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat & ~mask) == '0) |=> int_n); // R9

    AST_STAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_rd && host_addr == ADDR_ST1)
        |=> ((stat[DATA_W-1:0] & $past(stat[DATA_W-1:0])) == $past(stat[DATA_W-1:0]))); // R8
endmodule

bind rr_monitor rr_monitor_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .conv_req  (conv_req),
    .conv_ch   (conv_ch),
    .conv_rdy  (conv_rdy),
    .int_n     (int_n),
    .cfg_ie    (cfg_ie),
    .cfg_clr   (cfg_clr),
    .stat      (stat),
    .mask      (mask),
    .host_rd   (host_rd),
    .host_addr (host_addr)
);

// File: tb/rr_monitor_tb.sv
module rr_monitor_tb;
    localparam int CLK_PERIOD = 10;
    localparam int LOOP       = 900;
    localparam int SLOT       = LOOP / 9;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr = 1'b0;
    logic       host_rd = 1'b0;
    logic [5:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       conv_req;
    logic [3:0] conv_ch;
    logic       conv_rdy = 1'b0;
    logic [7:0] conv_data = '0;
    logic       int_n;

    int total = 0;
    int fails = 0;
    int cyc = 0;

    logic [7:0] chan_val [9];
    logic [7:0] hi_b [9];
    logic [7:0] lo_b [7];
    logic [8:0] mask_b = '0;
    logic [8:0] pend_b = '0;
    bit         ie_b = 0;
    bit         clr_b = 1;

    int log_ch [1024];
    int log_t  [1024];
    int start_cnt = 0;
    int done_cnt = 0;
    int last_done = -1;

    rr_monitor #(.LOOP_CYCLES(LOOP)) u_dut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .conv_req(conv_req), .conv_ch(conv_ch), .conv_rdy(conv_rdy),
        .conv_data(conv_data), .int_n(int_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Converter model: answers each request once after 0..3 cycles.
    initial begin
        bit busy;
        int lat;
        busy = 0;
        lat = 0;
        forever begin
            @(negedge clk);
            if (conv_rdy) begin
                conv_rdy = 1'b0;
            end else if (conv_req && rst_n) begin
                if (!busy) begin
                    busy = 1;
                    lat = int'($urandom % 4);
                    if (start_cnt < 1024) begin
                        log_ch[start_cnt] = int'(conv_ch);
                        log_t[start_cnt]  = cyc;
                    end
                    start_cnt++;
                end
                if (lat == 0) begin
                    conv_rdy  = 1'b1;
                    conv_data = chan_val[conv_ch];
                    busy = 0;
                    last_done = int'(conv_ch);
                    done_cnt++;
                end else begin
                    lat--;
                end
            end
        end
    end

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        total++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=done", cyc);
        summary();
        $finish;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic host_write(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic host_read(input logic [5:0] a, output logic [7:0] d);
        @(negedge clk);
        host_rd = 1'b1; host_addr = a;
        @(negedge clk);
        host_rd = 1'b0;
        d = host_rdata;
    endtask

    task automatic set_cfg(input logic [7:0] v);
        host_write(6'h00, v);
        ie_b  = v[1];
        clr_b = v[3];
    endtask

    task automatic wait_done(input int ch);
        int seen;
        seen = done_cnt;
        do @(negedge clk); while (!(done_cnt != seen && last_done == ch));
    endtask

    function automatic bit exp_fault(input int ch, input logic [7:0] v);
        if (ch >= 7) return v > hi_b[ch];
        if (ch == 0) return ($signed(v) > $signed(hi_b[0])) || ($signed(v) < $signed(lo_b[0]));
        return (v > hi_b[ch]) || (v < lo_b[ch]);
    endfunction

    function automatic bit exp_int_n();
        return !(ie_b && !clr_b && ((pend_b & ~mask_b) != 0));
    endfunction

    // One full pass with the current chan_val; optionally reads and clears status.
    task automatic run_round(input bit do_read, input string tag);
        logic [7:0] d1, d2;
        wait_done(8);
        for (int c = 0; c < 9; c++) if (exp_fault(c, chan_val[c])) pend_b[c] = 1'b1;
        repeat (3) @(negedge clk);
        check(int_n == exp_int_n(), {tag, " int_n"}, int'(int_n), int'(exp_int_n()));
        if (do_read) begin
            host_read(6'h01, d1);
            host_read(6'h02, d2);
            check(d1 == pend_b[7:0], {tag, " status1"}, int'(d1), int'(pend_b[7:0]));
            check(d2 == {7'b0, pend_b[8]}, {tag, " status2"}, int'(d2), int'(pend_b[8]));
            pend_b = '0;
        end
    endtask

    task automatic set_inrange();
        chan_val[0] = 8'h19;
        for (int c = 1; c < 7; c++) chan_val[c] = 8'h80 + 8'(c);
        chan_val[7] = 8'h60;
        chan_val[8] = 8'h90;
    endtask

    task automatic set_directed();
        chan_val[0] = 8'hF8;   // -8: in the signed window, above hi if unsigned
        chan_val[1] = 8'hC8;   // equal to hi
        chan_val[2] = 8'hC9;   // one above hi
        chan_val[3] = 8'h3F;   // one below lo
        chan_val[4] = 8'h40;   // equal to lo
        chan_val[5] = 8'h41;
        chan_val[6] = 8'hC7;
        chan_val[7] = 8'hA0;   // fan equal to limit
        chan_val[8] = 8'hFF;   // stopped fan
    endtask

    initial begin
        logic [7:0] d;
        int bad;
        int s0;
        void'($urandom(32'h0000_5EED));
        for (int c = 0; c < 9; c++) chan_val[c] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 reset state
        check(int_n == 1'b1, "R1 int_n after reset", int'(int_n), 1);
        check(conv_req == 1'b0, "R1 conv_req after reset", int'(conv_req), 0);
        host_read(6'h00, d);
        check(d == 8'h08, "R1 config reset value", int'(d), 8'h08);
        host_read(6'h01, d);
        check(d == 8'h00, "R1 status1 reset", int'(d), 0);
        repeat (50) @(negedge clk);
        check(start_cnt == 0, "R1 no request while clear bit set", start_cnt, 0);

        // Limits
        hi_b[0] = 8'h32; lo_b[0] = 8'hF6;
        for (int c = 1; c < 7; c++) begin hi_b[c] = 8'hC8; lo_b[c] = 8'h40; end
        hi_b[7] = 8'hA0; hi_b[8] = 8'hA0;
        for (int c = 0; c < 9; c++) host_write(6'h20 + 6'(c), hi_b[c]);
        for (int c = 0; c < 7; c++) host_write(6'h30 + 6'(c), lo_b[c]);

        // First pass: in range, order, spacing, readback
        set_inrange();
        set_cfg(8'h03);
        run_round(1, "R5 in-range pass");
        bad = 0;
        for (int i = 0; i < 9; i++) if (log_ch[i] != i) bad++;
        check(bad == 0, "R2 channel order", bad, 0);
        bad = 0;
        for (int i = 1; i < 9; i++) if (log_t[i] - log_t[i-1] != SLOT) bad++;
        check(bad == 0, "R3 slot spacing", log_t[1] - log_t[0], SLOT);
        for (int c = 0; c < 9; c++) begin
            host_read(6'h10 + 6'(c), d);
            check(d == chan_val[c], $sformatf("R4 reading ch%0d", c), int'(d), int'(chan_val[c]));
        end

        // Directed corner pass (R5 equal limits, R6 signed, R7 fan)
        set_directed();
        run_round(1, "R6 R7 directed pass");
        chan_val[0] = 8'hF5;   // -11 below the -10 limit
        chan_val[7] = 8'hA1;
        run_round(1, "R6 R7 second directed pass");

        // Random passes
        for (int r = 0; r < 6; r++) begin
            for (int c = 0; c < 9; c++) begin
                case ($urandom % 6)
                    0: chan_val[c] = hi_b[c];
                    1: chan_val[c] = hi_b[c] + 8'd1;
                    default: chan_val[c] = 8'($urandom);
                endcase
            end
            run_round(1, $sformatf("R5 random pass %0d", r));
        end

        // R8 sticky across an in-range pass, then clear on read
        set_directed();
        run_round(0, "R8 fault pass");
        set_inrange();
        run_round(1, "R8 sticky after in-range pass");
        host_read(6'h01, d);
        check(d == 8'h00, "R8 status1 cleared by read", int'(d), 0);
        host_read(6'h02, d);
        check(d == 8'h00, "R8 status2 cleared by read", int'(d), 0);

        // R9 masks
        host_write(6'h03, 8'hFF); host_write(6'h04, 8'h01); mask_b = 9'h1FF;
        set_directed();
        run_round(1, "R9 masked pass");
        host_write(6'h03, 8'h00); host_write(6'h04, 8'h00); mask_b = '0;

        // R10 enable gating
        set_cfg(8'h01);
        set_directed();
        run_round(0, "R10 disabled pass");
        set_cfg(8'h03);
        repeat (3) @(negedge clk);
        check(int_n == 1'b0, "R10 enable drives int_n low", int'(int_n), 0);

        // R11 clear: deassert, status kept, halt at pass end
        set_cfg(8'h0B);
        repeat (3) @(negedge clk);
        check(int_n == 1'b1, "R11 clear deasserts int_n", int'(int_n), 1);
        host_read(6'h01, d);
        check(d == pend_b[7:0], "R11 status1 unchanged", int'(d), int'(pend_b[7:0]));
        pend_b[7:0] = '0;
        s0 = start_cnt;
        repeat (3 * SLOT) @(negedge clk);
        check(start_cnt == s0, "R11 monitoring halted", start_cnt - s0, 0);

        // R13 restart at temperature
        s0 = start_cnt;
        set_cfg(8'h03);
        while (start_cnt == s0) @(negedge clk);
        check(log_ch[s0] == 0, "R13 restart channel", log_ch[s0], 0);

        // R12 stop mid-pass finishes the pass
        wait_done(3);
        s0 = start_cnt;
        set_cfg(8'h02);
        wait_done(8);
        bad = 0;
        for (int i = 0; i < 5; i++) if (log_ch[s0 + i] != 4 + i) bad++;
        check(bad == 0 && start_cnt - s0 == 5, "R12 rest of pass requested", start_cnt - s0, 5);
        s0 = start_cnt;
        repeat (3 * SLOT) @(negedge clk);
        check(start_cnt == s0, "R12 no request after pass", start_cnt - s0, 0);

        s0 = start_cnt;
        set_cfg(8'h03);
        while (start_cnt == s0) @(negedge clk);
        check(log_ch[s0] == 0, "R13 second restart channel", log_ch[s0], 0);

        summary();
        $finish;
    end
endmodule